// File: doc/BRIEF.md
# Blitter Parameter Register Bank

This block stores the operands for a 2D block-transfer engine. Software fills in two colours, a rectangle size, a pitch for each side, a source and a destination address and a mode byte. It then writes a control byte that launches the engine. Every parameter is driven on its own output port, so the engine reads them directly.

Bytes arrive on one of two write paths. The first is a direct path addressed by a byte offset. The second is an indexed legacy graphics-controller port: a small fixed table translates each of its indexes into one of the direct offsets. The chip identification value sets the generation. A newer part (ID 0xA8 or above) has 32-bit colours, 13-bit widths and 22-bit addresses. An older part has 16-bit colours, 11-bit widths and 21-bit addresses. These limits are applied to each byte at the moment it is written.

Top module: `blit_param_regs`

## Requirements
- R1: After reset all parameter outputs, `start_pulse` and `busy` are zero.
- R2: On a newer part, direct offsets 0x00..0x03 write background colour bytes 0..3 and offsets 0x04..0x07 write foreground colour bytes 0..3, with byte 0 the least significant.
- R3: On an older part, writes to offsets 0x02, 0x03, 0x06 and 0x07 leave both colours unchanged, and writes to bytes 0 and 1 leave colour bits 31:16 unchanged.
- R4: Offset 0x08 writes width bits 7:0. Offset 0x09 writes the upper width bits, keeping width to 13 bits on a newer part and to 11 bits on an older part.
- R5: Offset 0x0A writes height bits 7:0. Offset 0x0B writes the upper height bits, keeping height to 10 bits.
- R6: Offsets 0x0C/0x0D write the low/high bytes of the 16-bit destination pitch, and offsets 0x0E/0x0F do the same for the source pitch.
- R7: Offsets 0x10..0x12 write the destination address bytes, low first, and offsets 0x14..0x16 write the source address bytes. A write to the top byte keeps the address to 22 bits on a newer part and to 21 bits on an older part.
- R8: The indexed port maps index 0x00 to offset 0x00, 0x01 to 0x04, 0x10 to 0x01, 0x11 to 0x05, 0x12 to 0x02, 0x13 to 0x06, 0x14 to 0x03, 0x15 to 0x07 and 0x20 to 0x08.
- R9: An indexed write to any other index changes nothing. When both paths write in the same cycle, the direct path is used and the indexed write is dropped.
- R10: Offset 0x18 writes the 8-bit mode byte unchanged.
- R11: A write to offset 0x1A with bit 1 set while not busy makes `start_pulse` high for exactly the next cycle and sets `busy`. The same write while busy, or a write with bit 1 clear, produces no pulse.
- R12: `busy` clears in the cycle after `eng_done` is high. If a start and `eng_done` occur in the same cycle, `busy` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_id | input | 8 | Chip identification; 0xA8 or above selects the newer generation |
| mm_we | input | 1 | Direct-path byte write strobe |
| mm_off | input | 8 | Direct-path byte offset |
| mm_data | input | 8 | Direct-path write data |
| ix_we | input | 1 | Indexed-port byte write strobe |
| ix_idx | input | 8 | Indexed-port register index |
| ix_data | input | 8 | Indexed-port write data |
| eng_done | input | 1 | Engine completion indication |
| bg_color | output | 32 | Background colour |
| fg_color | output | 32 | Foreground colour |
| width | output | 13 | Rectangle width |
| height | output | 10 | Rectangle height |
| dst_pitch | output | 16 | Destination pitch |
| src_pitch | output | 16 | Source pitch |
| dst_addr | output | 22 | Destination address |
| src_addr | output | 22 | Source address |
| mode | output | 8 | Mode byte |
| start_pulse | output | 1 | One-cycle engine start |
| busy | output | 1 | Engine running |

## Verification
The same high bytes (0xFF) are written once with a newer chip ID and once with an older one. The two results show that the width and address limits depend on the generation. The older-generation writes to the upper colour bytes show that these bytes are truly ignored, not cleared. The indexed port is loaded with distinct values through all nine indexes, so that a swapped index shows up as a misplaced byte. Unmapped indexes and same-cycle writes on both paths then test the selection rule. The start sequence covers an idle start, a start while busy, a start without the start bit, and a start that coincides with `eng_done`.

// File: rtl/blit_param_regs.sv
module blit_param_regs #(
  parameter logic [7:0] NEW_GEN_ID = 8'hA8,
  parameter int WID_NEW  = 13,
  parameter int WID_OLD  = 11,
  parameter int HGT_W    = 10,
  parameter int ADDR_NEW = 22,
  parameter int ADDR_OLD = 21,
  parameter int START_BIT = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          chip_id,
  input  logic                mm_we,
  input  logic [7:0]          mm_off,
  input  logic [7:0]          mm_data,
  input  logic                ix_we,
  input  logic [7:0]          ix_idx,
  input  logic [7:0]          ix_data,
  input  logic                eng_done,
  output logic [31:0]         bg_color,
  output logic [31:0]         fg_color,
  output logic [WID_NEW-1:0]  width,
  output logic [HGT_W-1:0]    height,
  output logic [15:0]         dst_pitch,
  output logic [15:0]         src_pitch,
  output logic [ADDR_NEW-1:0] dst_addr,
  output logic [ADDR_NEW-1:0] src_addr,
  output logic [7:0]          mode,
  output logic                start_pulse,
  output logic                busy
);
  localparam logic [7:0] WHI_NEW = 8'((1 << (WID_NEW - 8)) - 1);
  localparam logic [7:0] WHI_OLD = 8'((1 << (WID_OLD - 8)) - 1);
  localparam logic [7:0] HHI     = 8'((1 << (HGT_W - 8)) - 1);
  localparam logic [7:0] AHI_NEW = 8'((1 << (ADDR_NEW - 16)) - 1);
  localparam logic [7:0] AHI_OLD = 8'((1 << (ADDR_OLD - 16)) - 1);
  localparam logic [7:0] OFF_MODE = 8'h18;
  localparam logic [7:0] OFF_CTL  = 8'h1A;

  logic       newer;
  logic       wr_en;
  logic [7:0] wr_off, wr_dat;
  logic       start_req;
  logic [7:0] w_hi, a_hi, h_hi;

  assign newer = (chip_id >= NEW_GEN_ID);
  assign w_hi  = wr_dat & (newer ? WHI_NEW : WHI_OLD);
  assign a_hi  = wr_dat & (newer ? AHI_NEW : AHI_OLD);
  assign h_hi  = wr_dat & HHI;
  assign start_req = wr_en && (wr_off == OFF_CTL) && wr_dat[START_BIT] && !busy;

  always_comb begin
    wr_en  = 1'b0;
    wr_off = 8'h00;
    wr_dat = mm_data;
    if (mm_we) begin
      wr_en  = 1'b1;
      wr_off = mm_off;
    end else if (ix_we) begin
      wr_dat = ix_data;
      wr_en  = 1'b1;
      case (ix_idx)
        8'h00:   wr_off = 8'h00;
        8'h01:   wr_off = 8'h04;
        8'h10:   wr_off = 8'h01;
        8'h11:   wr_off = 8'h05;
        8'h12:   wr_off = 8'h02;
        8'h13:   wr_off = 8'h06;
        8'h14:   wr_off = 8'h03;
        8'h15:   wr_off = 8'h07;
        8'h20:   wr_off = 8'h08;
        default: wr_en  = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bg_color  <= '0;
      fg_color  <= '0;
      width     <= '0;
      height    <= '0;
      dst_pitch <= '0;
      src_pitch <= '0;
      dst_addr  <= '0;
      src_addr  <= '0;
      mode      <= '0;
    end else if (wr_en) begin
      case (wr_off)
        8'h00: bg_color[7:0]   <= wr_dat;
        8'h01: bg_color[15:8]  <= wr_dat;
        8'h02: if (newer) bg_color[23:16] <= wr_dat;
        8'h03: if (newer) bg_color[31:24] <= wr_dat;
        8'h04: fg_color[7:0]   <= wr_dat;
        8'h05: fg_color[15:8]  <= wr_dat;
        8'h06: if (newer) fg_color[23:16] <= wr_dat;
        8'h07: if (newer) fg_color[31:24] <= wr_dat;
        8'h08: width[7:0]      <= wr_dat;
        8'h09: width           <= {w_hi[WID_NEW-9:0], width[7:0]};
        8'h0A: height[7:0]     <= wr_dat;
        8'h0B: height          <= {h_hi[HGT_W-9:0], height[7:0]};
        8'h0C: dst_pitch[7:0]  <= wr_dat;
        8'h0D: dst_pitch[15:8] <= wr_dat;
        8'h0E: src_pitch[7:0]  <= wr_dat;
        8'h0F: src_pitch[15:8] <= wr_dat;
        8'h10: dst_addr[7:0]   <= wr_dat;
        8'h11: dst_addr[15:8]  <= wr_dat;
        8'h12: dst_addr        <= {a_hi[ADDR_NEW-17:0], dst_addr[15:0]};
        8'h14: src_addr[7:0]   <= wr_dat;
        8'h15: src_addr[15:8]  <= wr_dat;
        8'h16: src_addr        <= {a_hi[ADDR_NEW-17:0], src_addr[15:0]};
        OFF_MODE: mode         <= wr_dat;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      busy        <= 1'b0;
    end else begin
      start_pulse <= start_req;
      if (start_req)     busy <= 1'b1;
      else if (eng_done) busy <= 1'b0;
    end
  end

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  assert_pulse_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> busy);

  assert_busy_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(eng_done));

  assert_width_old_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mm_we && mm_off == 8'h09 && chip_id < NEW_GEN_ID)
      |-> width[WID_NEW-1:WID_OLD] == '0);

  assert_old_colour_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mm_we && mm_off == 8'h02 && chip_id < NEW_GEN_ID)
      |-> bg_color[31:16] == $past(bg_color[31:16]));

  assert_height_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mm_we && mm_off == 8'h0B && mm_data == 8'hFF) |-> height[HGT_W-1:8] == '1);
endmodule

// File: tb/tb_blit_param_regs.sv
module tb_blit_param_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  chip_id = 8'hA8;
  logic        mm_we = 1'b0, ix_we = 1'b0, eng_done = 1'b0;
  logic [7:0]  mm_off = '0, mm_data = '0, ix_idx = '0, ix_data = '0;
  logic [31:0] bg_color, fg_color;
  logic [12:0] width;
  logic [9:0]  height;
  logic [15:0] dst_pitch, src_pitch;
  logic [21:0] dst_addr, src_addr;
  logic [7:0]  mode;
  logic        start_pulse, busy;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  blit_param_regs dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic mw, input logic [7:0] mo, input logic [7:0] md,
                     input logic iw, input logic [7:0] ii, input logic [7:0] id,
                     input logic dn);
    @(negedge clk);
    mm_we = mw; mm_off = mo; mm_data = md;
    ix_we = iw; ix_idx = ii; ix_data = id; eng_done = dn;
    @(negedge clk);
    mm_we = 0; ix_we = 0; eng_done = 0;
  endtask

  task automatic mw(input logic [7:0] o, input logic [7:0] d);
    cyc(1, o, d, 0, 0, 0, 0);
  endtask

  task automatic iw(input logic [7:0] i, input logic [7:0] d);
    cyc(0, 0, 0, 1, i, d, 0);
  endtask

  task automatic t_reset;
    chk("R1 bg", bg_color, 0); chk("R1 fg", fg_color, 0);
    chk("R1 width", 32'(width), 0); chk("R1 height", 32'(height), 0);
    chk("R1 addr", 32'(dst_addr | src_addr), 0);
    chk("R1 start/busy", {30'b0, start_pulse, busy}, 0);
  endtask

  task automatic t_colour_new;
    chip_id = 8'hA8;
    mw(8'h00, 8'h11); mw(8'h01, 8'h22); mw(8'h02, 8'h33); mw(8'h03, 8'h44);
    mw(8'h04, 8'h55); mw(8'h05, 8'h66); mw(8'h06, 8'h77); mw(8'h07, 8'h88);
    chk("R2 bg", bg_color, 32'h44332211);
    chk("R2 fg", fg_color, 32'h88776655);
  endtask

  task automatic t_colour_old;
    chip_id = 8'hA0;
    mw(8'h02, 8'h99); mw(8'h03, 8'h99); mw(8'h06, 8'h99); mw(8'h07, 8'h99);
    chk("R3 bg ignored", bg_color, 32'h44332211);
    chk("R3 fg ignored", fg_color, 32'h88776655);
    mw(8'h00, 8'hA5); mw(8'h05, 8'h5A);
    chk("R3 bg low", bg_color, 32'h443322A5);
    chk("R3 fg low", fg_color, 32'h88775A55);
  endtask

  task automatic t_width;
    chip_id = 8'hA8;
    mw(8'h08, 8'hAB); mw(8'h09, 8'hFF);
    chk("R4 width new", 32'(width), 32'h1FAB);
    chip_id = 8'h9C;
    mw(8'h09, 8'hFF);
    chk("R4 width old", 32'(width), 32'h07AB);
  endtask

  task automatic t_height;
    mw(8'h0A, 8'h34); mw(8'h0B, 8'hFF);
    chk("R5 height", 32'(height), 32'h3FF & 32'h334 | 32'h334);
    mw(8'h0B, 8'h01);
    chk("R5 height low hi", 32'(height), 32'h134);
  endtask

  task automatic t_pitch;
    mw(8'h0C, 8'h01); mw(8'h0D, 8'h02); mw(8'h0E, 8'hCD); mw(8'h0F, 8'hAB);
    chk("R6 dst pitch", 32'(dst_pitch), 32'h0201);
    chk("R6 src pitch", 32'(src_pitch), 32'hABCD);
  endtask

  task automatic t_addr;
    chip_id = 8'hB8;
    mw(8'h10, 8'h11); mw(8'h11, 8'h22); mw(8'h12, 8'hFF);
    chk("R7 dst new", 32'(dst_addr), 32'h3F2211);
    chip_id = 8'hA7;
    mw(8'h14, 8'h33); mw(8'h15, 8'h44); mw(8'h16, 8'hFF);
    chk("R7 src old", 32'(src_addr), 32'h1F4433);
  endtask

  task automatic t_indexed;
    chip_id = 8'hA8;
    iw(8'h00, 8'hA1); iw(8'h10, 8'hA2); iw(8'h12, 8'hA3); iw(8'h14, 8'hA4);
    iw(8'h01, 8'hB1); iw(8'h11, 8'hB2); iw(8'h13, 8'hB3); iw(8'h15, 8'hB4);
    iw(8'h20, 8'h77);
    chk("R8 bg", bg_color, 32'hA4A3A2A1);
    chk("R8 fg", fg_color, 32'hB4B3B2B1);
    chk("R8 width low", 32'(width[7:0]), 32'h77);
  endtask

  task automatic t_ignored;
    iw(8'h02, 8'h5A); iw(8'h08, 8'h5A); iw(8'h21, 8'h5A); iw(8'h18, 8'h5A);
    chk("R9 bg unchanged", bg_color, 32'hA4A3A2A1);
    chk("R9 fg unchanged", fg_color, 32'hB4B3B2B1);
    chk("R9 width unchanged", 32'(width[7:0]), 32'h77);
    chk("R9 mode unchanged", 32'(mode), 0);
    cyc(1, 8'h00, 8'h01, 1, 8'h00, 8'h02, 0);
    chk("R9 direct wins", bg_color, 32'hA4A3A201);
  endtask

  task automatic t_mode;
    mw(8'h18, 8'h5C);
    chk("R10 mode", 32'(mode), 32'h5C);
  endtask

  task automatic t_start;
    mw(8'h1A, 8'hFD);
    chk("R11 no start bit", {30'b0, start_pulse, busy}, 0);
    mw(8'h1A, 8'h02);
    chk("R11 pulse+busy", {30'b0, start_pulse, busy}, 3);
    @(negedge clk);
    chk("R11 pulse one cycle", {30'b0, start_pulse, busy}, 1);
    mw(8'h1A, 8'h02);
    chk("R11 ignored while busy", {30'b0, start_pulse, busy}, 1);
  endtask

  task automatic t_done;
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R12 busy cleared", {30'b0, start_pulse, busy}, 0);
    cyc(1, 8'h1A, 8'h02, 0, 0, 0, 1);
    chk("R12 start beats done", {30'b0, start_pulse, busy}, 3);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R12 clear after", {30'b0, start_pulse, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_colour_new();
    t_colour_old();
    t_width();
    t_height();
    t_pitch();
    t_addr();
    t_indexed();
    t_ignored();
    t_mode();
    t_start();
    t_done();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule